// File: doc/BRIEF.md
# Bus Target Read Prefetch Controller

This block serves read bursts from a bus master out of a local word buffer that it fills from system memory ahead of demand. When a master opens a read, the block decodes the command type and chooses how many 32-bit words to request. A plain read, a cache-line read and a multiple-line read each take their size from their own tuning register. The fetched words land in a 1024-word FIFO. Whenever the words held or still on their way drop to a programmable low-water mark, another request goes out. The request never asks for more words than the FIFO has room for.

If a data phase finds the buffer empty, the master is told to retry and fetching carries on. A read that returns to the next undelivered address is then served from the buffer. A read aimed at the register-space region fetches exactly one word and disconnects with it. If a burst ends or a read opens at a different address, everything still buffered or in flight is discarded.

Top module: `rd_prefetch_ctrl`

## Requirements
- R1: A plain read (bus_cmd 0, also reserved code 3) issues its first memory request at the opening address with a length equal to the plain size register (cfg_sel 0).
- R2: A multiple read (bus_cmd 2) issues its first request with a length equal to the multiple size register (cfg_sel 1).
- R3: A line read (bus_cmd 1) requests one cache line of the length in the line size register (cfg_sel 2). When that register is zero, the length is the plain size instead.
- R4: Writes to the plain size register are clamped into 2..32, and writes to the multiple size register are clamped into 8..1024.
- R5: cfg_bad is high exactly when the threshold (cfg_sel 3) is not below the smallest of the plain size, the multiple size and a non-zero line size.
- R6: A data phase that finds no buffered word answers with bus_retry and no bus_ack. Fetching continues, and a new opening at the next undelivered address reuses the buffer without a new request.
- R7: While a burst is live, a further request is issued only when buffered plus in-flight words are at or below the threshold. Its address follows on from the previous request, and its length is the smaller of the session size and the free FIFO space.
- R8: A read with bus_regspace high requests a single word, delivers it with bus_stop and bus_ack together, and issues no further request.
- R9: On bus_end, or on an opening at an address other than the next undelivered one, all buffered and in-flight words are discarded. The next burst delivers only its own data.
- R10: Words are delivered in address order, each carrying the memory data of its address.
- R11: FIFO occupancy plus outstanding words never exceed the 1024-word capacity.
- R12: After reset no request, acknowledge or retry is driven, cfg_bad is low, and the tuning registers hold plain 8, multiple 64, line 8 and threshold 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Tuning register write strobe |
| cfg_sel | input | 2 | Register select: 0 plain, 1 multiple, 2 line, 3 threshold |
| cfg_wdata | input | 11 | Write value |
| cfg_bad | output | 1 | Threshold rule violated |
| bus_start | input | 1 | Master opens a read (address phase) |
| bus_cmd | input | 2 | Read command: 0 plain, 1 line, 2 multiple |
| bus_addr | input | 32 | Word address of the opening |
| bus_regspace | input | 1 | Opening targets register space |
| bus_req | input | 1 | Master wants a data word this cycle |
| bus_end | input | 1 | Master finishes its burst |
| bus_ack | output | 1 | Data word delivered this cycle |
| bus_data | output | 32 | Delivered word |
| bus_retry | output | 1 | No data available, master must retry |
| bus_stop | output | 1 | Disconnect after this word |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | First word address of the request |
| mem_req_len | output | 11 | Number of words requested |
| mem_rd_valid | input | 1 | Returned word valid |
| mem_rd_data | input | 32 | Returned word |

## Verification
The assertions assume that memory returns exactly the words it accepted, in request order, one per cycle at most. They also assume the master never raises bus_req together with bus_start or bus_end, and never raises bus_end right after a retry it intends to repeat. The directed tasks keep to this. Every strobe lasts one cycle and is dropped before the next one. Data phases only follow an opening. The bench memory model queues the accepted addresses and replays them in order, and it can be paused to hold data in flight across a flush.

// File: rtl/pf_pkg.sv
package pf_pkg;
    localparam int unsigned PF_DEPTH = 1024;
    localparam int unsigned PF_CW    = $clog2(PF_DEPTH) + 1;

    typedef logic [PF_CW-1:0] cnt_t;

    localparam cnt_t PLAIN_MIN = cnt_t'(2);
    localparam cnt_t PLAIN_MAX = cnt_t'(32);
    localparam cnt_t MULTI_MIN = cnt_t'(8);
    localparam cnt_t MULTI_MAX = cnt_t'(PF_DEPTH);

    typedef enum logic [1:0] {
        CMD_READ  = 2'd0,
        CMD_LINE  = 2'd1,
        CMD_MULTI = 2'd2,
        CMD_RSVD  = 2'd3
    } rd_cmd_e;

    typedef enum logic [1:0] {
        SEL_PLAIN = 2'd0,
        SEL_MULTI = 2'd1,
        SEL_LINE  = 2'd2,
        SEL_THR   = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        cnt_t plain;
        cnt_t multi;
        cnt_t line;
        cnt_t thr;
    } tune_t;

    typedef struct packed {
        logic live;
        logic oneshot;
        logic issued;
        cnt_t size;
    } sess_t;

    function automatic cnt_t clamp(cnt_t v, cnt_t lo, cnt_t hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    // Words to fetch per request for a newly opened read
    function automatic cnt_t pick_size(rd_cmd_e c, logic regspace, tune_t t);
        if (regspace) return cnt_t'(1);
        case (c)
            CMD_LINE:  return (t.line != '0) ? t.line : t.plain;
            CMD_MULTI: return t.multi;
            default:   return t.plain;
        endcase
    endfunction

    function automatic logic tune_bad(tune_t t);
        cnt_t low;
        low = (t.plain < t.multi) ? t.plain : t.multi;
        if (t.line != '0 && t.line < low) low = t.line;
        return t.thr >= low;
    endfunction
endpackage

// File: rtl/pf_tune_regs.sv
module pf_tune_regs
    import pf_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     we,
    input  cfg_sel_e sel,
    input  cnt_t     wdata,
    output tune_t    tune,
    output logic     bad
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tune.plain <= cnt_t'(8);
            tune.multi <= cnt_t'(64);
            tune.line  <= cnt_t'(8);
            tune.thr   <= cnt_t'(4);
        end else if (we) begin
            case (sel)
                SEL_PLAIN: tune.plain <= clamp(wdata, PLAIN_MIN, PLAIN_MAX);
                SEL_MULTI: tune.multi <= clamp(wdata, MULTI_MIN, MULTI_MAX);
                SEL_LINE:  tune.line  <= (wdata > MULTI_MAX) ? MULTI_MAX : wdata;
                default:   tune.thr   <= wdata;
            endcase
        end
    end

    always_comb bad = tune_bad(tune);
endmodule

// File: rtl/pf_word_fifo.sv
module pf_word_fifo #(
    parameter int unsigned DEPTH = 1024,
    parameter int unsigned DW    = 32,
    localparam int unsigned IW   = $clog2(DEPTH),
    localparam int unsigned CW   = IW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] count,
    output logic          empty
);
    logic [DW-1:0] store [DEPTH];
    logic [IW-1:0] wr_ptr, rd_ptr;

    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    always_comb begin
        rdata = store[rd_ptr];
        empty = (count == '0);
    end
endmodule

// File: rtl/pf_req_gen.sv
module pf_req_gen
    import pf_pkg::*;
#(
    parameter int unsigned DEPTH = PF_DEPTH
) (
    input  logic live,
    input  logic oneshot,
    input  logic issued,
    input  cnt_t pending,
    input  cnt_t size,
    input  cnt_t thr,
    output logic valid,
    output cnt_t len
);
    cnt_t room;

    always_comb begin
        room  = cnt_t'(DEPTH) - pending;
        len   = (size < room) ? size : room;
        valid = live && (pending <= thr) && !(oneshot && issued) && (room != '0);
    end
endmodule

// File: rtl/rd_prefetch_ctrl.sv
module rd_prefetch_ctrl
    import pf_pkg::*;
#(
    parameter int unsigned DEPTH = PF_DEPTH,
    parameter int unsigned AW    = 32,
    parameter int unsigned DW    = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [PF_CW-1:0] cfg_wdata,
    output logic             cfg_bad,
    input  logic             bus_start,
    input  logic [1:0]       bus_cmd,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_regspace,
    input  logic             bus_req,
    input  logic             bus_end,
    output logic             bus_ack,
    output logic [DW-1:0]    bus_data,
    output logic             bus_retry,
    output logic             bus_stop,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [AW-1:0]    mem_req_addr,
    output logic [PF_CW-1:0] mem_req_len,
    input  logic             mem_rd_valid,
    input  logic [DW-1:0]    mem_rd_data
);
    tune_t         tune;
    sess_t         sess;
    logic [AW-1:0] next_addr, fetch_addr;
    cnt_t          fifo_cnt, outstanding, discard, pending, out_next;
    logic          fifo_empty, hit, open_new, flush, accept, drop_now, push;

    pf_tune_regs u_tune (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .sel   (cfg_sel_e'(cfg_sel)),
        .wdata (cfg_wdata),
        .tune  (tune),
        .bad   (cfg_bad)
    );

    pf_word_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .clr   (flush),
        .push  (push),
        .wdata (mem_rd_data),
        .pop   (bus_ack),
        .rdata (bus_data),
        .count (fifo_cnt),
        .empty (fifo_empty)
    );

    pf_req_gen #(.DEPTH(DEPTH)) u_req (
        .live    (sess.live),
        .oneshot (sess.oneshot),
        .issued  (sess.issued),
        .pending (pending),
        .size    (sess.size),
        .thr     (tune.thr),
        .valid   (mem_req_valid),
        .len     (mem_req_len)
    );

    always_comb begin
        hit       = sess.live && (bus_addr == next_addr);
        open_new  = bus_start && !hit;
        flush     = bus_end || open_new;
        bus_ack   = bus_req && sess.live && !fifo_empty;
        bus_retry = bus_req && !bus_ack;
        bus_stop  = bus_ack && sess.oneshot;
        accept    = mem_req_valid && mem_req_ready;
        drop_now  = mem_rd_valid && (discard != '0);
        push      = mem_rd_valid && !drop_now && !flush;
        pending   = fifo_cnt + (outstanding - discard);
        out_next  = outstanding + (accept ? mem_req_len : '0) - cnt_t'(mem_rd_valid);
        mem_req_addr = fetch_addr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sess        <= '0;
            next_addr   <= '0;
            fetch_addr  <= '0;
            outstanding <= '0;
            discard     <= '0;
        end else begin
            outstanding <= out_next;
            discard     <= flush ? out_next : discard - cnt_t'(drop_now);
            if (accept) begin
                fetch_addr  <= fetch_addr + AW'(mem_req_len);
                sess.issued <= 1'b1;
            end
            if (bus_ack) next_addr <= next_addr + 1'b1;
            if (open_new) begin
                sess.live    <= 1'b1;
                sess.oneshot <= bus_regspace;
                sess.issued  <= 1'b0;
                sess.size    <= pick_size(rd_cmd_e'(bus_cmd), bus_regspace, tune);
                fetch_addr   <= bus_addr;
                next_addr    <= bus_addr;
            end else if (bus_end) begin
                sess.live <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pf_checker.sv
module pf_checker
    import pf_pkg::*;
#(
    parameter int unsigned DEPTH = PF_DEPTH
) (
    input logic clk,
    input logic rst,
    input logic bus_ack,
    input logic bus_stop,
    input logic mem_req_valid,
    input cnt_t mem_req_len,
    input cnt_t fifo_cnt,
    input cnt_t pending,
    input cnt_t plain,
    input cnt_t multi
);
    p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
        fifo_cnt <= cnt_t'(DEPTH));

    p_req_fits_r11: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> ({1'b0, pending} + {1'b0, mem_req_len}) <= (PF_CW + 1)'(DEPTH));

    p_ack_has_data_r6: assert property (@(posedge clk) disable iff (rst)
        bus_ack |-> fifo_cnt != '0);

    p_stop_single_r8: assert property (@(posedge clk) disable iff (rst)
        bus_stop |=> !bus_stop);

    p_req_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> mem_req_len != '0);

    p_plain_range_r4: assert property (@(posedge clk) disable iff (rst)
        plain >= PLAIN_MIN && plain <= PLAIN_MAX);

    p_multi_range_r4: assert property (@(posedge clk) disable iff (rst)
        multi >= MULTI_MIN && multi <= MULTI_MAX);
endmodule

bind rd_prefetch_ctrl pf_checker #(.DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_ack       (bus_ack),
    .bus_stop      (bus_stop),
    .mem_req_valid (mem_req_valid),
    .mem_req_len   (mem_req_len),
    .fifo_cnt      (fifo_cnt),
    .pending       (pending),
    .plain         (tune.plain),
    .multi         (tune.multi)
);

// File: tb/tb_rd_prefetch_ctrl.sv
`timescale 1ns/1ps
module tb_rd_prefetch_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [10:0] cfg_wdata = '0;
    logic        cfg_bad;
    logic        bus_start = 1'b0;
    logic [1:0]  bus_cmd = '0;
    logic [31:0] bus_addr = '0;
    logic        bus_regspace = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_end = 1'b0;
    logic        bus_ack, bus_retry, bus_stop;
    logic [31:0] bus_data;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [31:0] mem_req_addr;
    logic [10:0] mem_req_len;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;

    int checks = 0;
    int fails  = 0;
    logic mem_pause = 1'b0;
    logic [31:0] q [4096];
    int qh = 0, qt = 0;
    int req_cnt = 0;
    int last_len = 0;
    logic [31:0] last_addr = '0;

    always #2.5 clk = ~clk;

    rd_prefetch_ctrl dut (.*);

    function automatic logic [31:0] fdat(logic [31:0] a);
        return {a[15:0] ^ 16'hC3C3, ~a[15:0]};
    endfunction

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // memory model: replays accepted addresses in order, one word per cycle
    initial begin
        forever begin
            @(negedge clk);
            if (!mem_pause && qh != qt) begin
                mem_rd_valid = 1'b1;
                mem_rd_data  = fdat(q[qh]);
                qh = (qh + 1) % 4096;
            end else begin
                mem_rd_valid = 1'b0;
            end
            if (!rst && mem_req_valid && mem_req_ready) begin
                for (int k = 0; k < int'(mem_req_len); k++) begin
                    q[qt] = mem_req_addr + k;
                    qt = (qt + 1) % 4096;
                end
                req_cnt++;
                last_len  = int'(mem_req_len);
                last_addr = mem_req_addr;
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input logic [1:0] sel, input int val);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = 11'(val);
        cyc(1);
        cfg_we = 1'b0;
    endtask

    task automatic open_rd(input logic [31:0] a, input logic [1:0] cmd, input logic rs);
        bus_start = 1'b1; bus_addr = a; bus_cmd = cmd; bus_regspace = rs;
        cyc(1);
        bus_start = 1'b0; bus_regspace = 1'b0;
    endtask

    task automatic end_burst();
        bus_end = 1'b1;
        cyc(1);
        bus_end = 1'b0;
    endtask

    task automatic drain();
        end_burst();
        while (qh != qt) cyc(1);
        cyc(3);
    endtask

    task automatic read_burst(input logic [31:0] a0, input int n, input string tag);
        int got = 0, bad = 0, spins = 0;
        logic [31:0] ba = '0, be = '0;
        while (got < n && spins < 5000) begin
            bus_req = 1'b1;
            #1;
            if (bus_ack) begin
                if (bus_data !== fdat(a0 + got)) begin
                    if (bad == 0) begin ba = bus_data; be = fdat(a0 + got); end
                    bad++;
                end
                got++;
            end
            cyc(1);
            spins++;
        end
        bus_req = 1'b0;
        chk(got == n, {tag, " word count"}, got, n);
        chk(bad == 0, {tag, " data"}, ba, be);
    endtask

    task automatic t_reset();
        #1;
        chk(!bus_ack && !bus_retry && !mem_req_valid, "R12 idle outputs",
            {bus_ack, bus_retry, mem_req_valid}, 0);
        chk(cfg_bad == 1'b0, "R12 cfg_bad", cfg_bad, 0);
        open_rd(32'h40, 2'd2, 1'b0);
        cyc(2);
        chk(last_len == 64, "R12 default multi size", last_len, 64);
        drain();
    endtask

    task automatic t_clamp();
        int c0;
        cfg(2'd0, 40);
        c0 = req_cnt;
        open_rd(32'h10, 2'd0, 1'b0);
        cyc(2);
        chk(req_cnt == c0 + 1 && last_len == 32, "R4 plain clamp high / R1", last_len, 32);
        chk(last_addr == 32'h10, "R1 request address", last_addr, 32'h10);
        drain();
        cfg(2'd0, 1);
        open_rd(32'h20, 2'd3, 1'b0);
        cyc(2);
        chk(last_len == 2, "R4 plain clamp low (reserved cmd as plain R1)", last_len, 2);
        drain();
        cfg(2'd1, 3);
        open_rd(32'h30, 2'd2, 1'b0);
        cyc(2);
        chk(last_len == 8, "R4 multi clamp low / R2", last_len, 8);
        drain();
    endtask

    task automatic t_refill();
        int c0;
        cfg(2'd0, 4);
        cfg(2'd3, 2);
        mem_pause = 1'b1;
        c0 = req_cnt;
        open_rd(32'h100, 2'd0, 1'b0);
        cyc(2);
        chk(req_cnt == c0 + 1 && last_len == 4 && last_addr == 32'h100, "R1 first plain request",
            last_len, 4);
        bus_req = 1'b1;
        #1;
        chk(bus_retry && !bus_ack, "R6 retry when empty", {bus_retry, bus_ack}, 2'b10);
        cyc(1);
        bus_req = 1'b0;
        cyc(5);
        chk(req_cnt == c0 + 1, "R7 no refill above threshold", req_cnt, c0 + 1);
        mem_pause = 1'b0;
        cyc(8);
        open_rd(32'h100, 2'd0, 1'b0);
        cyc(1);
        chk(req_cnt == c0 + 1, "R6 retried open reuses buffer", req_cnt, c0 + 1);
        read_burst(32'h100, 2, "R6 R10 first words");
        cyc(2);
        chk(req_cnt == c0 + 2 && last_addr == 32'h104 && last_len == 4, "R7 refill at threshold",
            last_addr, 32'h104);
        read_burst(32'h102, 4, "R10 ordered data across refill");
        drain();
    endtask

    task automatic t_discard();
        mem_pause = 1'b1;
        open_rd(32'h300, 2'd0, 1'b0);
        cyc(2);
        end_burst();
        open_rd(32'h400, 2'd0, 1'b0);
        mem_pause = 1'b0;
        read_burst(32'h400, 3, "R9 in-flight words discarded");
        open_rd(32'h600, 2'd0, 1'b0);
        read_burst(32'h600, 2, "R9 leftover dropped on new address");
        drain();
    endtask

    task automatic t_line();
        cfg(2'd2, 16);
        open_rd(32'h700, 2'd1, 1'b0);
        cyc(2);
        chk(last_len == 16 && last_addr == 32'h700, "R3 line size", last_len, 16);
        drain();
        cfg(2'd2, 0);
        open_rd(32'h740, 2'd1, 1'b0);
        cyc(2);
        chk(last_len == 4, "R3 zero line size falls back to plain", last_len, 4);
        drain();
    endtask

    task automatic t_multi();
        cfg(2'd1, 100);
        open_rd(32'h800, 2'd2, 1'b0);
        cyc(2);
        chk(last_len == 100, "R2 multi size", last_len, 100);
        read_burst(32'h800, 5, "R10 multi data");
        drain();
    endtask

    task automatic t_cfgbad();
        #1;
        chk(cfg_bad == 1'b0, "R5 legal threshold", cfg_bad, 0);
        cfg(2'd3, 4);
        #1;
        chk(cfg_bad == 1'b1, "R5 threshold equals plain size", cfg_bad, 1);
        cfg(2'd3, 3);
        #1;
        chk(cfg_bad == 1'b0, "R5 threshold below all", cfg_bad, 0);
        cfg(2'd2, 2);
        #1;
        chk(cfg_bad == 1'b1, "R5 line size smallest", cfg_bad, 1);
        cfg(2'd2, 8);
        #1;
        chk(cfg_bad == 1'b0, "R5 line size raised", cfg_bad, 0);
    endtask

    task automatic t_regspace();
        int c0;
        c0 = req_cnt;
        open_rd(32'h50, 2'd2, 1'b1);
        cyc(2);
        chk(req_cnt == c0 + 1 && last_len == 1 && last_addr == 32'h50, "R8 single word request",
            last_len, 1);
        cyc(4);
        bus_req = 1'b1;
        #1;
        chk(bus_ack && bus_stop, "R8 stop with first word", {bus_ack, bus_stop}, 2'b11);
        chk(bus_data == fdat(32'h50), "R8 R10 register word", bus_data, fdat(32'h50));
        cyc(1);
        bus_req = 1'b0;
        cyc(4);
        bus_req = 1'b1;
        #1;
        chk(bus_retry && !bus_ack && req_cnt == c0 + 1, "R8 no further fetch", req_cnt, c0 + 1);
        cyc(1);
        bus_req = 1'b0;
        drain();
    endtask

    task automatic t_capacity();
        int c0;
        cfg(2'd1, 1024);
        cfg(2'd3, 7);
        c0 = req_cnt;
        open_rd(32'h1000, 2'd2, 1'b0);
        cyc(2);
        chk(last_len == 1024, "R2 full multi size", last_len, 1024);
        cyc(1030);
        chk(req_cnt == c0 + 1, "R11 no request while full", req_cnt, c0 + 1);
        read_burst(32'h1000, 1017, "R10 long burst");
        cyc(2);
        chk(req_cnt == c0 + 2 && last_len == 1017 && last_addr == 32'h1400,
            "R7 R11 refill capped by free space", last_len, 1017);
        drain();
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_clamp();
        t_refill();
        t_discard();
        t_line();
        t_multi();
        t_cfgbad();
        t_regspace();
        t_capacity();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule